// File: doc/BRIEF.md
# Prescaled Timer with Deferred Register Updates

This block is a 16-bit general-purpose timer with an 8-bit prescaler in front of the main counter. It counts down or up, in one-shot or periodic mode. Software sets the interval-load value, the prescale value, the counter value and a match point through a simple register write port, and reads them back through a registered read port. Two configuration bits decide when writes take effect. For the interval-load and prescale pair, a write takes effect on the next cycle or waits for the next timeout. The match pair has its own bit with the same choice.

A sticky timeout flag and a sticky match flag tell software what happened; both are cleared by writing ones to the status register. A debug-halt input can freeze the count when the stall bit is set. A separate real-time bit keeps the timer running through a halt.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `timeout_flag`, `match_flag` and `rd_data` are 0. Reset leaves the control register at 0 (disabled), the interval-load value and the counter at 0xFFFF, and prescale, match and prescale-match at 0.
- R2: The prescaler counts from 0 up to the active prescale value p. The main counter steps once when the prescaler reaches p, so each count lasts p+1 clocks. Every counter load or timeout restarts the prescaler at 0. Example: down-counting from 3 with p=1, the timeout comes on the 8th enabled clock.
- R3: When counting down, the counter decrements on each prescale step. It times out on the step taken at 0, and in periodic mode it reloads the interval-load value.
- R4: When counting up, the counter increments on each prescale step. It times out on the step taken while it is at or above the interval-load value, then restarts from 0.
- R5: In one-shot mode a timeout clears the enable bit (control bit 0) unless the control register is written in the same cycle.
- R6: When counting down with the deferred-load bit (control bit 5) clear, a write to the interval-load register (address 1) or the prescale register (address 2) reloads the counter on the next cycle. The counter takes the newly written interval value and the new prescale applies at once.
- R7: When counting down with the deferred-load bit set, interval-load and prescale writes do not disturb the count. The new values are used at the next timeout.
- R8: When counting up, interval-load and prescale writes move the timeout point and step length from the next cycle on, without reloading the counter.
- R9: A write to the value register (address 3) loads the counter on the next cycle in either direction, and counting continues from it.
- R10: A match is detected while running, when the counter equals the active match value and the prescaler equals the active prescale-match value; it sets `match_flag`. Match (address 4) and prescale-match (address 5) writes become active on the next cycle when the match-update bit (control bit 6) is clear. When it is set, they wait for the next timeout.
- R11: With the stall bit (control bit 3) set, the real-time bit (control bit 4) clear and `debug_halt` high, counter and prescaler hold still. Setting the real-time bit lets counting continue through the halt.
- R12: `timeout_flag` sets on a timeout and stays set. A write to status (address 6) with bit 0 set clears it, and bit 1 set clears `match_flag`. A set in the same cycle wins over a clear.
- R13: `rd_data` returns, one cycle after `rd_addr` is presented, the selected register. The map is 0 control (bits 0 enable, 1 periodic, 2 count up, 3 stall, 4 real-time, 5 deferred load, 6 deferred match), 1 interval-load, 2 prescale, 3 counter, 4 match, 5 prescale-match, 6 status (bit 0 timeout, bit 1 match) and 7 prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| debug_halt | input | 1 | Processor halted by debugger |
| timeout_flag | output | 1 | Sticky timeout indication |
| match_flag | output | 1 | Sticky match indication |

## Verification
The counter is run down and up with prescale values 0, 1 and 2. This separates step length from count length, and a hand-counted timeout cycle pins the period formula. The same interval-load and prescale writes are issued with the deferred bit clear and set, in both directions. An immediate reload, a deferred commit and a moved up-count limit therefore each produce a different counter trace. Match writes are repeated under both match-update settings. Debug halt is applied with the stall bit alone and then with the real-time bit added, and a one-shot run confirms the enable drops.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_LOAD   = 3'd1,
    REG_PRE    = 3'd2,
    REG_VALUE  = 3'd3,
    REG_MATCH  = 3'd4,
    REG_PMATCH = 3'd5,
    REG_STATUS = 3'd6,
    REG_PSCNT  = 3'd7
  } reg_sel_e;

  // enable sits in bit 0, defer_match in bit 6
  typedef struct packed {
    logic defer_match;
    logic defer_load;
    logic rt_keep;
    logic stall;
    logic count_up;
    logic periodic;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_shadow.sv
// Software-visible register paired with the copy the timer actually uses.
module ptmr_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         imm,
  input  logic         commit,
  input  logic [W-1:0] din,
  output logic [W-1:0] sw_q,
  output logic [W-1:0] act_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q  <= '0;
      act_q <= '0;
    end else begin
      if (wr) sw_q <= din;
      if (wr && imm) begin
        act_q <= din;
      end else if (commit) begin
        act_q <= sw_q;
      end
    end
  end

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic [PRE_W-1:0] pcnt,
  output logic             tick
);

  // at-or-above keeps a lowered limit from causing a long wrap
  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (restart) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             count_up,
  input  logic             force_load,
  input  logic [CNT_W-1:0] force_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout_ev
);

  logic at_end;

  always_comb begin
    if (count_up) at_end = (cnt >= limit);
    else          at_end = (cnt == '0);
  end

  assign timeout_ev = tick && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (force_load) begin
      cnt <= force_val;
    end else if (timeout_ev) begin
      cnt <= count_up ? '0 : limit;
    end else if (tick) begin
      cnt <= count_up ? cnt + 1'b1 : cnt - 1'b1;
    end
  end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             debug_halt,
  output logic             timeout_flag,
  output logic             match_flag
);
  import ptmr_pkg::*;

  ptmr_pkg::ctrl_t  ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] match_q, match_act;
  logic [PRE_W-1:0] pre_q, pre_act, pmatch_q, pmatch_act, pcnt;
  logic             run, tick, restart, timeout_ev, match_hit;
  logic             w_ctrl, w_load, w_pre, w_value, w_match, w_pmatch, w_status;
  logic             force_load;
  logic [CNT_W-1:0] force_val;
  logic [CNT_W-1:0] rd_next;

  assign w_ctrl   = wr_en && (wr_addr == REG_CTRL);
  assign w_load   = wr_en && (wr_addr == REG_LOAD);
  assign w_pre    = wr_en && (wr_addr == REG_PRE);
  assign w_value  = wr_en && (wr_addr == REG_VALUE);
  assign w_match  = wr_en && (wr_addr == REG_MATCH);
  assign w_pmatch = wr_en && (wr_addr == REG_PMATCH);
  assign w_status = wr_en && (wr_addr == REG_STATUS);

  // halt freezes only with stall set and the real-time bit clear
  assign run = ctrl_q.enable && !(ctrl_q.stall && !ctrl_q.rt_keep && debug_halt);

  // immediate down-count reload on interval or prescale write
  assign force_load = w_value ||
                      ((w_load || w_pre) && !ctrl_q.count_up && !ctrl_q.defer_load);
  assign force_val  = (w_value || w_load) ? wr_data : load_q;
  assign restart    = force_load || timeout_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '1;
    end else begin
      if (w_ctrl) begin
        ctrl_q <= ptmr_pkg::ctrl_t'(wr_data[CTRL_W-1:0]);
      end else if (timeout_ev && !ctrl_q.periodic) begin
        ctrl_q.enable <= 1'b0;
      end
      if (w_load) load_q <= wr_data;
    end
  end

  ptmr_shadow #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .wr(w_pre),
    .imm(ctrl_q.count_up || !ctrl_q.defer_load),
    .commit(timeout_ev), .din(wr_data[PRE_W-1:0]),
    .sw_q(pre_q), .act_q(pre_act)
  );

  ptmr_shadow #(.W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .wr(w_match), .imm(!ctrl_q.defer_match),
    .commit(timeout_ev), .din(wr_data),
    .sw_q(match_q), .act_q(match_act)
  );

  ptmr_shadow #(.W(PRE_W)) u_pmatch (
    .clk(clk), .rst(rst), .wr(w_pmatch), .imm(!ctrl_q.defer_match),
    .commit(timeout_ev), .din(wr_data[PRE_W-1:0]),
    .sw_q(pmatch_q), .act_q(pmatch_act)
  );

  ptmr_prescaler #(.PRE_W(PRE_W)) u_pscl (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .limit(pre_act), .pcnt(pcnt), .tick(tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count_up(ctrl_q.count_up),
    .force_load(force_load), .force_val(force_val), .limit(load_q),
    .cnt(cnt), .timeout_ev(timeout_ev)
  );

  assign match_hit = run && (cnt == match_act) && (pcnt == pmatch_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_flag <= 1'b0;
      match_flag   <= 1'b0;
    end else begin
      if (timeout_ev)                   timeout_flag <= 1'b1;
      else if (w_status && wr_data[0])  timeout_flag <= 1'b0;
      if (match_hit)                    match_flag <= 1'b1;
      else if (w_status && wr_data[1])  match_flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      REG_CTRL:   rd_next = CNT_W'(ctrl_q);
      REG_LOAD:   rd_next = load_q;
      REG_PRE:    rd_next = CNT_W'(pre_q);
      REG_VALUE:  rd_next = cnt;
      REG_MATCH:  rd_next = match_q;
      REG_PMATCH: rd_next = CNT_W'(pmatch_q);
      REG_STATUS: rd_next = CNT_W'({match_flag, timeout_flag});
      default:    rd_next = CNT_W'(pcnt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             run,
  input logic             tick,
  input logic             restart,
  input logic             timeout_ev,
  input logic [CNT_W-1:0] cnt,
  input logic [PRE_W-1:0] pcnt,
  input ptmr_pkg::ctrl_t  ctrl_q,
  input logic [PRE_W-1:0] pre_act,
  input logic [CNT_W-1:0] match_act,
  input logic             timeout_flag
);
  import ptmr_pkg::*;

  assert_prescale_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !restart) |=> (pcnt == $past(pcnt) + 1'b1));

  assert_timeout_sets_R3: assert property (@(posedge clk) disable iff (rst)
    timeout_ev |=> timeout_flag);

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (timeout_ev && !ctrl_q.periodic && !(wr_en && wr_addr == REG_CTRL)) |=> !ctrl_q.enable);

  assert_deferred_prescale_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_PRE && !ctrl_q.count_up && ctrl_q.defer_load && !timeout_ev)
    |=> $stable(pre_act));

  assert_value_load_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_VALUE) |=> (cnt == $past(wr_data)));

  assert_deferred_match_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_MATCH && ctrl_q.defer_match && !timeout_ev) |=> $stable(match_act));

  assert_frozen_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> ($stable(cnt) && $stable(pcnt)));

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !(wr_en && wr_addr == REG_STATUS && wr_data[0])) |=> timeout_flag);

endmodule

bind prescaled_timer ptmr_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run), .tick(tick), .restart(restart), .timeout_ev(timeout_ev),
  .cnt(cnt), .pcnt(pcnt), .ctrl_q(ctrl_q), .pre_act(pre_act),
  .match_act(match_act), .timeout_flag(timeout_flag)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd3;
  logic [15:0] rd_data;
  logic        debug_halt = 1'b0;
  logic        timeout_flag, match_flag;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .debug_halt(debug_halt),
    .timeout_flag(timeout_flag), .match_flag(match_flag)
  );

  // behavioural reference state
  logic        m_en, m_per, m_up, m_stall, m_rt, m_dl, m_dm;
  logic [15:0] m_load, m_cnt, m_match, m_match_eff, m_rd;
  logic [7:0]  m_pre, m_pre_eff, m_pm, m_pm_eff, m_pc;
  logic        m_tof, m_mf;
  // scratch
  logic        t_run, t_tick, t_to, t_hit, t_force;
  logic        w_c, w_l, w_p, w_v, w_m, w_pm, w_s;
  logic [15:0] n_cnt, n_match_eff, n_rd;
  logic [7:0]  n_pc, n_pre_eff, n_pm_eff;

  always @(posedge clk) begin
    if (rst) begin
      {m_en, m_per, m_up, m_stall, m_rt, m_dl, m_dm} = '0;
      m_load = 16'hFFFF; m_cnt = 16'hFFFF;
      m_match = 0; m_match_eff = 0; m_pre = 0; m_pre_eff = 0;
      m_pm = 0; m_pm_eff = 0; m_pc = 0; m_tof = 0; m_mf = 0; m_rd = 0;
    end else begin
      w_c  = wr_en && wr_addr == 3'd0;
      w_l  = wr_en && wr_addr == 3'd1;
      w_p  = wr_en && wr_addr == 3'd2;
      w_v  = wr_en && wr_addr == 3'd3;
      w_m  = wr_en && wr_addr == 3'd4;
      w_pm = wr_en && wr_addr == 3'd5;
      w_s  = wr_en && wr_addr == 3'd6;
      t_run  = m_en && !(m_stall && !m_rt && debug_halt);
      t_tick = t_run && (m_pc >= m_pre_eff);
      t_to   = t_tick && (m_up ? (m_cnt >= m_load) : (m_cnt == 16'd0));
      t_hit  = t_run && (m_cnt == m_match_eff) && (m_pc == m_pm_eff);
      t_force = w_v || ((w_l || w_p) && !m_up && !m_dl);
      case (rd_addr)
        3'd0: n_rd = {9'd0, m_dm, m_dl, m_rt, m_stall, m_up, m_per, m_en};
        3'd1: n_rd = m_load;
        3'd2: n_rd = {8'd0, m_pre};
        3'd3: n_rd = m_cnt;
        3'd4: n_rd = m_match;
        3'd5: n_rd = {8'd0, m_pm};
        3'd6: n_rd = {14'd0, m_mf, m_tof};
        default: n_rd = {8'd0, m_pc};
      endcase
      if (w_v)               n_cnt = wr_data;
      else if (t_force)      n_cnt = w_l ? wr_data : m_load;
      else if (t_to)         n_cnt = m_up ? 16'd0 : m_load;
      else if (t_tick)       n_cnt = m_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
      else                   n_cnt = m_cnt;
      if (t_force || t_to)   n_pc = 0;
      else if (t_run)        n_pc = t_tick ? 8'd0 : m_pc + 8'd1;
      else                   n_pc = m_pc;
      if (w_p && (m_up || !m_dl)) n_pre_eff = wr_data[7:0];
      else if (t_to)              n_pre_eff = m_pre;
      else                        n_pre_eff = m_pre_eff;
      if (w_m && !m_dm)      n_match_eff = wr_data;
      else if (t_to)         n_match_eff = m_match;
      else                   n_match_eff = m_match_eff;
      if (w_pm && !m_dm)     n_pm_eff = wr_data[7:0];
      else if (t_to)         n_pm_eff = m_pm;
      else                   n_pm_eff = m_pm_eff;
      if (w_c) {m_dm, m_dl, m_rt, m_stall, m_up, m_per, m_en} = wr_data[6:0];
      else if (t_to && !m_per) m_en = 1'b0;
      if (w_l)  m_load  = wr_data;
      if (w_p)  m_pre   = wr_data[7:0];
      if (w_m)  m_match = wr_data;
      if (w_pm) m_pm    = wr_data[7:0];
      if (t_to) m_tof = 1'b1; else if (w_s && wr_data[0]) m_tof = 1'b0;
      if (t_hit) m_mf = 1'b1; else if (w_s && wr_data[1]) m_mf = 1'b0;
      m_cnt = n_cnt; m_pc = n_pc; m_pre_eff = n_pre_eff;
      m_match_eff = n_match_eff; m_pm_eff = n_pm_eff; m_rd = n_rd;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (rd_data !== m_rd || timeout_flag !== m_tof || match_flag !== m_mf) begin
        fails++;
        $display("FAIL %s: rd_data=%h exp=%h timeout=%b exp=%b match=%b exp=%b",
                 cur_req, rd_data, m_rd, timeout_flag, m_tof, match_flag, m_mf);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=0 cycles left", WATCHDOG);
    finish_run();
  end

  logic [15:0] held;

  initial begin
    // R1: reset state
    idle(3);
    chk(timeout_flag == 0 && match_flag == 0 && rd_data == 0, "R1", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(timeout_flag == 0 && match_flag == 0, "R1", timeout_flag, 0);
    idle(2);

    // R6 / R3: immediate load, down periodic
    cur_req = "R6";
    wr(3'd1, 16'd5);
    wr(3'd0, 16'h0003);
    cur_req = "R3";
    idle(20);
    chk(timeout_flag == 1, "R3", timeout_flag, 1);
    cur_req = "R6";
    idle(2);
    wr(3'd1, 16'd9);
    idle(15);

    // R12: clear while running
    cur_req = "R12";
    wr(3'd6, 16'h0003);
    idle(12);

    // R2: prescale 1, value 3 -> timeout on the 8th enabled clock
    cur_req = "R2";
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h0003);
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0003);
    idle(7);
    chk(timeout_flag == 0, "R2", timeout_flag, 0);
    idle(1);
    chk(timeout_flag == 1, "R2", timeout_flag, 1);
    idle(10);

    // R7: deferred load in down mode
    cur_req = "R7";
    wr(3'd0, 16'h0023);
    wr(3'd1, 16'd4);
    idle(3);
    wr(3'd2, 16'd0);
    idle(40);

    // R4 / R8: up counting, limit and prescale moved
    cur_req = "R4";
    wr(3'd0, 16'h0007);
    wr(3'd3, 16'd0);
    idle(25);
    cur_req = "R8";
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd2);
    idle(30);

    // R9: value writes in both directions
    cur_req = "R9";
    wr(3'd3, 16'd1);
    idle(8);
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'd6);
    idle(10);

    // R10: match, immediate then deferred
    cur_req = "R10";
    wr(3'd2, 16'd0);
    wr(3'd1, 16'd7);
    wr(3'd4, 16'd3);
    wr(3'd5, 16'd0);
    idle(20);
    wr(3'd6, 16'h0003);
    wr(3'd0, 16'h0043);
    wr(3'd4, 16'd5);
    idle(4);
    wr(3'd6, 16'h0002);
    idle(20);

    // R11: stall freezes, real-time bit overrides
    cur_req = "R11";
    debug_halt = 1'b1;
    wr(3'd0, 16'h000B);
    idle(2);
    held = rd_data;
    idle(6);
    chk(rd_data == held, "R11", rd_data, held);
    wr(3'd0, 16'h001B);
    idle(12);
    debug_halt = 1'b0;
    wr(3'd0, 16'h000B);
    idle(6);

    // R5: one-shot stops itself
    cur_req = "R5";
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'h0001);
    idle(10);
    rd_addr = 3'd0;
    idle(2);
    chk(rd_data[0] == 1'b0, "R5", rd_data[0], 0);

    // R13: walk the read map
    cur_req = "R13";
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      idle(2);
    end
    rd_addr = 3'd3;
    idle(2);

    finish_run();
  end

endmodule